// File: doc/BRIEF.md
# Port-Width Transfer Splitter

This block sits between an internal requester and a narrow external data bus. An internal request carries an address, a direction and a size: byte, word (2 bytes), longword (4 bytes) or a 16-byte line, plus write data. The block turns that request into a series of external beats whose width matches a programmed port of 8, 16 or 32 bits. It places each beat on either the upper or the lower byte lanes of a 32-bit bus, drives active-low byte enables and a burst flag, and packs read beats back into one result.

Transfers wider than the port go out either as one burst or as a run of separate single transfers. Bursting is enabled independently for reads and for writes. Configuration is sampled when a request is accepted, so it may change freely while a transfer is running.

All three data paths use valid/ready handshakes:
- **Request channel.** A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle.
- **Beat channel.** A beat completes on a cycle where `bt_valid` and `bt_ready` are both high. While `bt_ready` is low, every beat output holds steady.
- **Response channel.** After the last beat the block raises `rsp_valid`. It holds `rsp_rdata` until `rsp_ready` is seen, and only then accepts a new request.

Top module: `xfer_port_splitter`

## Requirements
- R1: Port code 00 selects a 32-bit port, 01 an 8-bit port, and both 10 and 11 a 16-bit port. Beat width is the smaller of the port width and the transfer size. The beat count is the transfer size divided by the beat width. Size codes are 00 byte, 01 word, 10 longword, 11 line (16 bytes).
- R2: With lane-low clear, an 8-bit port uses bus bits 31:24 and a 16-bit port uses bits 31:16. With lane-low set, they use bits 7:0 and 15:0. Within a port, a lower byte address sits on a higher lane. Lanes not carrying beat data read as zero on `bt_data`.
- R3: The first beat address is the (size-aligned) request address. Each later beat address rises by the beat width in bytes.
- R4: When burst-write is enabled and a write needs more than one beat, every beat has `bt_burst`=1 and only the final beat has `bt_last`=1. Otherwise write beats have `bt_burst`=0 and `bt_last`=1.
- R5: Burst-read controls reads in the same way as R4, independently of burst-write.
- R6: `bt_be_n` is 0 on each lane carrying beat data and 1 elsewhere, for writes always. For reads this holds only when byte-enables-on-read is set; when it is clear, reads drive `bt_be_n`=1111.
- R7: For reads, `rsp_rdata` holds the transfer's bytes right-aligned. The byte at the lowest address is the most significant. For writes, `rsp_rdata` is zero.
- R8: Write beats carry `req_wdata` (right-aligned) most significant byte first: the first beat takes the top bytes of the transfer.
- R9: Handshakes:
  - `req_ready` is high only when idle.
  - Beat outputs stay unchanged while `bt_valid` is high and `bt_ready` is low.
  - `rsp_valid` and `rsp_rdata` stay unchanged until `rsp_ready`.
  - Beats and the response are never valid together.
- R10: Configuration inputs are sampled at request acceptance. Changing them during a transfer has no effect on that transfer.
- R11: After reset, `req_ready`=1, `bt_valid`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_port_code | input | 2 | Port width code (R1) |
| cfg_lane_low | input | 1 | 1: narrow port on low lanes |
| cfg_burst_wr | input | 1 | Burst enable for writes |
| cfg_burst_rd | input | 1 | Burst enable for reads |
| cfg_be_on_read | input | 1 | 1: byte enables also driven on reads |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | Transfer size code |
| req_addr | input | ADDR_W | Byte address, aligned to size |
| req_wdata | input | LINE_BYTES*8 | Write data, right-aligned |
| bt_valid | output | 1 | Beat valid |
| bt_ready | input | 1 | Beat accepted by bus |
| bt_write | output | 1 | Beat direction |
| bt_addr | output | ADDR_W | Beat byte address |
| bt_data | output | 32 | Write data on lanes |
| bt_be_n | output | 4 | Active-low byte enables |
| bt_burst | output | 1 | Beat is part of a burst |
| bt_last | output | 1 | Beat ends a bus transaction |
| bt_rdata | input | 32 | Read data, sampled at beat handshake |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_rdata | output | LINE_BYTES*8 | Assembled read data |

## Verification
Some internal faults show up on the beat channel as soon as the next beat is offered:
- A wrong beat counter gives the wrong number of beats. This shows as a missing or early `rsp_valid`, or a stray `bt_last`, within the same transfer.
- A faulty shift register or lane index puts wrong data or enables on the lanes in the very beat it affects.

An error in the read packer only shows at `rsp_valid`, one cycle after the final beat. Because the response holds the packed bytes, any misordering is visible there.

Configuration that is not latched correctly shows up on beats after a mid-transfer change of the `cfg_*` pins.

// File: rtl/psplit_pkg.sv
package psplit_pkg;

  localparam int unsigned BUS_BYTES = 4;
  localparam int unsigned BUS_BITS  = BUS_BYTES * 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LINE = 2'd3
  } xfer_size_e;

  typedef struct packed {
    logic [1:0] port_code;
    logic       lane_low;
    logic       burst_wr;
    logic       burst_rd;
    logic       be_on_rd;
  } split_cfg_t;

  // log2 of port width in bytes: 00 -> 4 B, 01 -> 1 B, 1x -> 2 B
  function automatic logic [2:0] port_lg2(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd2;
      2'b01:   return 3'd0;
      default: return 3'd1;
    endcase
  endfunction

  // log2 of transfer size in bytes
  function automatic logic [2:0] size_lg2(input xfer_size_e sz, input logic [2:0] line_lg);
    case (sz)
      SZ_BYTE: return 3'd0;
      SZ_WORD: return 3'd1;
      SZ_LONG: return 3'd2;
      default: return line_lg;
    endcase
  endfunction

endpackage

// File: rtl/psplit_plan.sv
module psplit_plan
  import psplit_pkg::*;
#(
  parameter int unsigned LINE_LG = 4
) (
  input  logic [1:0]         port_code,
  input  xfer_size_e         size,
  input  logic               write,
  input  logic               burst_wr,
  input  logic               burst_rd,
  output logic [2:0]         beat_lg,
  output logic [2:0]         xfer_lg,
  output logic [LINE_LG-1:0] beats_m1,
  output logic               burst
);
  logic [2:0] p_lg;
  logic [2:0] steps;

  always_comb begin
    p_lg     = port_lg2(port_code);
    xfer_lg  = size_lg2(size, 3'(LINE_LG));
    beat_lg  = (xfer_lg < p_lg) ? xfer_lg : p_lg;
    steps    = xfer_lg - beat_lg;
    beats_m1 = LINE_LG'((LINE_LG+1)'(1) << steps) - LINE_LG'(1);
    // R4 / R5: burst only when the direction allows it and more than one beat
    burst    = (write ? burst_wr : burst_rd) && (steps != 3'd0);
  end
endmodule

// File: rtl/psplit_lane_steer.sv
module psplit_lane_steer
  import psplit_pkg::*;
(
  input  logic [2:0]          beat_lg,
  input  logic [2:0]          port_lg,
  input  logic                lane_low,
  input  logic [1:0]          offset,
  input  logic [BUS_BITS-1:0] beat_left,
  input  logic [BUS_BITS-1:0] rdata,
  output logic [BUS_BITS-1:0] lane_data,
  output logic [BUS_BYTES-1:0] lane_mask,
  output logic [BUS_BITS-1:0] rd_left
);
  int unsigned pbytes;
  int unsigned bbytes;
  int unsigned base;
  int          lane;
  logic [1:0]  li;

  always_comb begin
    lane_data = '0;
    lane_mask = '0;
    rd_left   = '0;
    li        = '0;
    pbytes    = 32'd1 << port_lg;
    bbytes    = 32'd1 << beat_lg;
    base      = lane_low ? 0 : (BUS_BYTES - pbytes);
    for (int j = 0; j < BUS_BYTES; j++) begin
      lane = int'(base + pbytes) - 1 - int'(offset) - j;
      if (j < int'(bbytes) && lane >= 0 && lane < int'(BUS_BYTES)) begin
        li = lane[1:0];
        // R2: big-endian byte j lands on lane li; R8: byte j is the j-th most significant
        lane_data[8*li +: 8]        = beat_left[BUS_BITS-1-8*j -: 8];
        lane_mask[li]               = 1'b1;
        rd_left[BUS_BITS-1-8*j -: 8] = rdata[8*li +: 8];
      end
    end
  end
endmodule

// File: rtl/psplit_read_pack.sv
module psplit_read_pack
  import psplit_pkg::*;
#(
  parameter int unsigned LINE_BITS = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 capture,
  input  logic [2:0]           beat_lg,
  input  logic [BUS_BITS-1:0]  rd_left,
  output logic [LINE_BITS-1:0] acc
);
  logic [5:0] beat_bits;
  logic [BUS_BITS-1:0] beat_val;

  always_comb begin
    beat_bits = 6'd8 << beat_lg;
    beat_val  = rd_left >> (6'd32 - beat_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (clear)   acc <= '0;
    else if (capture) acc <= (acc << beat_bits) | LINE_BITS'(beat_val);
  end

  // R7: the packer never captures and clears together
  assert_pack_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear && capture));
endmodule

// File: rtl/xfer_port_splitter.sv
module xfer_port_splitter
  import psplit_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 16,
  localparam int unsigned LINE_BITS = LINE_BYTES * 8,
  localparam int unsigned LINE_LG   = $clog2(LINE_BYTES),
  localparam int unsigned SH_W      = LINE_LG + 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_port_code,
  input  logic                  cfg_lane_low,
  input  logic                  cfg_burst_wr,
  input  logic                  cfg_burst_rd,
  input  logic                  cfg_be_on_read,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LINE_BITS-1:0]  req_wdata,
  output logic                  bt_valid,
  input  logic                  bt_ready,
  output logic                  bt_write,
  output logic [ADDR_W-1:0]     bt_addr,
  output logic [BUS_BITS-1:0]   bt_data,
  output logic [BUS_BYTES-1:0]  bt_be_n,
  output logic                  bt_burst,
  output logic                  bt_last,
  input  logic [BUS_BITS-1:0]   bt_rdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [LINE_BITS-1:0]  rsp_rdata
);

  typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_RESP} state_e;

  state_e               state_q;
  split_cfg_t           cfg_q;
  logic [ADDR_W-1:0]    addr_q;
  logic                 write_q;
  logic [LINE_BITS-1:0] shreg_q;
  logic [LINE_LG-1:0]   idx_q;
  logic [LINE_LG-1:0]   beats_m1_q;
  logic [2:0]           beat_lg_q;
  logic                 burst_q;

  logic [2:0]           pl_beat_lg;
  logic [2:0]           pl_xfer_lg;
  logic [LINE_LG-1:0]   pl_beats_m1;
  logic                 pl_burst;

  logic                 accept;
  logic                 beat_fire;
  logic                 final_beat;
  logic [SH_W-1:0]      align_sh;
  logic [5:0]           beat_bits;
  logic [1:0]           offset;
  logic [2:0]           port_lg_q;
  logic [BUS_BITS-1:0]  lane_data;
  logic [BUS_BYTES-1:0] lane_mask;
  logic [BUS_BITS-1:0]  rd_left;
  logic [LINE_BITS-1:0] acc;

  psplit_plan #(.LINE_LG(LINE_LG)) u_plan (
    .port_code (cfg_port_code),
    .size      (xfer_size_e'(req_size)),
    .write     (req_write),
    .burst_wr  (cfg_burst_wr),
    .burst_rd  (cfg_burst_rd),
    .beat_lg   (pl_beat_lg),
    .xfer_lg   (pl_xfer_lg),
    .beats_m1  (pl_beats_m1),
    .burst     (pl_burst)
  );

  always_comb begin
    req_ready  = (state_q == ST_IDLE);
    accept     = req_valid && req_ready;
    bt_valid   = (state_q == ST_BEAT);
    beat_fire  = bt_valid && bt_ready;
    final_beat = (idx_q == beats_m1_q);
    rsp_valid  = (state_q == ST_RESP);
    align_sh   = SH_W'(LINE_BITS) - (SH_W'(8) << pl_xfer_lg);
    beat_bits  = 6'd8 << beat_lg_q;
    port_lg_q  = port_lg2(cfg_q.port_code);
    offset     = addr_q[1:0] & ~(2'b11 << port_lg_q);
  end

  psplit_lane_steer u_steer (
    .beat_lg   (beat_lg_q),
    .port_lg   (port_lg_q),
    .lane_low  (cfg_q.lane_low),
    .offset    (offset),
    .beat_left (shreg_q[LINE_BITS-1 -: BUS_BITS]),
    .rdata     (bt_rdata),
    .lane_data (lane_data),
    .lane_mask (lane_mask),
    .rd_left   (rd_left)
  );

  psplit_read_pack #(.LINE_BITS(LINE_BITS)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .capture (beat_fire && !write_q),
    .beat_lg (beat_lg_q),
    .rd_left (rd_left),
    .acc     (acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cfg_q      <= '0;
      addr_q     <= '0;
      write_q    <= 1'b0;
      shreg_q    <= '0;
      idx_q      <= '0;
      beats_m1_q <= '0;
      beat_lg_q  <= '0;
      burst_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          // R10: configuration captured once, here
          cfg_q      <= '{port_code: cfg_port_code, lane_low: cfg_lane_low,
                          burst_wr: cfg_burst_wr, burst_rd: cfg_burst_rd,
                          be_on_rd: cfg_be_on_read};
          addr_q     <= req_addr;
          write_q    <= req_write;
          shreg_q    <= req_wdata << align_sh;
          idx_q      <= '0;
          beats_m1_q <= pl_beats_m1;
          beat_lg_q  <= pl_beat_lg;
          burst_q    <= pl_burst;
          state_q    <= ST_BEAT;
        end
        ST_BEAT: if (beat_fire) begin
          addr_q  <= addr_q + (ADDR_W'(1) << beat_lg_q);
          shreg_q <= shreg_q << beat_bits;
          idx_q   <= idx_q + LINE_LG'(1);
          if (final_beat) state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bt_write  = write_q;
    bt_addr   = addr_q;
    bt_data   = write_q ? lane_data : '0;
    bt_be_n   = (write_q || cfg_q.be_on_rd) ? ~lane_mask : '1;
    bt_burst  = burst_q;
    bt_last   = !burst_q || final_beat;
    rsp_rdata = write_q ? '0 : acc;
  end

  // ---------------- assertions ----------------
  assert_beat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bt_valid && !bt_ready |=> bt_valid && $stable(bt_addr) && $stable(bt_data)
      && $stable(bt_be_n) && $stable(bt_last) && $stable(bt_burst));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  assert_chan_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bt_valid && rsp_valid) && !(req_ready && bt_valid));

  assert_split_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bt_valid && !bt_burst |-> bt_last);

  assert_burst_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && bt_burst && !bt_last |=> bt_valid && bt_burst);

  assert_rd_be_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bt_valid && !bt_write && !cfg_q.be_on_rd |-> bt_be_n == '1);

  assert_low_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bt_valid && cfg_q.lane_low && cfg_q.port_code == 2'b01 |-> bt_be_n[3:1] == 3'b111);

  assert_high_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bt_valid && !cfg_q.lane_low && cfg_q.port_code[1] |-> bt_be_n[1:0] == 2'b11);

endmodule

// File: tb/tb_xfer_port_splitter.sv
module tb_xfer_port_splitter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]   cfg_port_code = '0;
  logic         cfg_lane_low = 0, cfg_burst_wr = 0, cfg_burst_rd = 0, cfg_be_on_read = 0;
  logic         req_valid = 0, req_write = 0;
  logic [1:0]   req_size = '0;
  logic [31:0]  req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic         bt_ready = 0, rsp_ready = 0;
  logic [31:0]  bt_rdata = '0;
  logic         req_ready, bt_valid, bt_write, bt_burst, bt_last, rsp_valid;
  logic [31:0]  bt_addr, bt_data;
  logic [3:0]   bt_be_n;
  logic [127:0] rsp_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  xfer_port_splitter dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_b(input logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  // R2 lane rule written per port width
  function automatic int exp_lane(input int p, input bit low, input int k);
    if (p == 4) return 3 - k;
    if (p == 1) return low ? 0 : 3;
    return low ? (1 - k) : (3 - k);
  endfunction

  task automatic run_req(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                         input logic [127:0] wd, input logic [1:0] pc, input bit low,
                         input bit bw, input bit br, input bit ber);
    int s, p, b, n, i, k0, ln, gap;
    bit burst, rdy;
    logic [31:0]  ea, ed, rd;
    logic [3:0]   ebe;
    logic [7:0]   by;
    logic [127:0] ersp;
    s = (sz == 2'd3) ? 16 : (1 << sz);
    p = (pc == 2'b00) ? 4 : (pc == 2'b01) ? 1 : 2;
    b = (s < p) ? s : p;
    n = s / b;
    burst = (wr ? bw : br) && (n > 1);
    cfg_port_code = pc; cfg_lane_low = low; cfg_burst_wr = bw; cfg_burst_rd = br;
    cfg_be_on_read = ber;
    req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R9 idle ready", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 busy not ready", req_ready, 0);
    i = 0;
    while (i < n) begin
      ea = a + i * b;
      k0 = ea % p;
      ed = '0; ebe = 4'hF; rd = $urandom;
      for (int j = 0; j < b; j++) begin
        ln = exp_lane(p, low, k0 + j);
        by = wr ? wd[8*(s-1-(i*b+j)) +: 8] : mem_b(a + i*b + j);
        ed[8*ln +: 8] = by;
        rd[8*ln +: 8] = by;
        if (wr || ber) ebe[ln] = 1'b0;
      end
      chk(bt_valid == 1'b1, "R1 beat present", bt_valid, 1);
      chk(bt_addr == ea, "R3 beat address", bt_addr, ea);
      chk(bt_write == wr, "R9 beat direction", bt_write, wr);
      if (wr) chk(bt_burst == burst, "R4 write burst flag", bt_burst, burst);
      else    chk(bt_burst == burst, "R5 read burst flag", bt_burst, burst);
      chk(bt_last == (!burst || i == n-1), "R4 last flag", bt_last, (!burst || i == n-1));
      chk(bt_be_n == ebe, "R6 byte enables", bt_be_n, ebe);
      if (wr) chk(bt_data == ed, "R2 R8 write lanes", bt_data, ed);
      rdy = ($urandom % 4) != 0;
      bt_ready = rdy;
      bt_rdata = rd;
      // R10: scramble configuration mid-transfer
      {cfg_port_code, cfg_lane_low, cfg_burst_wr, cfg_burst_rd, cfg_be_on_read} = 6'($urandom);
      @(negedge clk);
      if (rdy) i++;
    end
    bt_ready = 1'b0;
    ersp = '0;
    if (!wr) for (int j = 0; j < s; j++) ersp = (ersp << 8) | 128'(mem_b(a + j));
    chk(rsp_valid == 1'b1, "R1 response after beat count", rsp_valid, 1);
    chk(bt_valid == 1'b0, "R9 no beat with response", bt_valid, 0);
    chk(rsp_rdata == ersp, "R7 assembled data", rsp_rdata, ersp);
    gap = $urandom % 3;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b1 && rsp_rdata == ersp, "R9 response held", rsp_rdata, ersp);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 back to idle", rsp_valid, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R9 actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [1:0] sz;
    logic [31:0] a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11 reset ready", req_ready, 1);
    chk(bt_valid == 1'b0, "R11 reset beat", bt_valid, 0);
    chk(rsp_valid == 1'b0, "R11 reset response", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_req(32'h100, 2'd2, 1'b1, 128'hA1B2C3D4, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0); // R4 long->8 burst high
    run_req(32'h104, 2'd2, 1'b1, 128'h11223344, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0); // R4 split low
    run_req(32'h200, 2'd3, 1'b0, '0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1);           // R5 line read burst
    run_req(32'h210, 2'd3, 1'b0, '0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);           // R5 independent of bw
    run_req(32'h303, 2'd0, 1'b1, 128'h5E, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);      // R2 byte offset 3
    run_req(32'h402, 2'd1, 1'b0, '0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1);           // R1 code 11 = 16-bit
    run_req(32'h500, 2'd3, 1'b1, 128'h0F0E0D0C0B0A09080706050403020100,
            2'b01, 1'b1, 1'b1, 1'b0, 1'b0);                                   // R8 line to 8-bit
    run_req(32'h601, 2'd0, 1'b0, '0, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0);           // R6 read, no enables
    for (int r = 0; r < 300; r++) begin
      sz = 2'($urandom);
      a = $urandom & ~32'((sz == 2'd3) ? 15 : ((1 << sz) - 1));
      run_req(a, sz, 1'($urandom), {$urandom, $urandom, $urandom, $urandom},
              2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule